// File: doc/BRIEF.md
# Paired-Instruction Accumulator Sequencer

This block is the fetch/execute controller of a small accumulator machine. Every 40-bit memory word holds two 20-bit instructions. A word fetch reads the whole word and runs its left instruction first. The right instruction is parked in an instruction buffer register and is run from there, with no further memory access. The program counter moves on only after both halves of a word have run. The datapath holds a program counter, a memory address register, a memory buffer register, an instruction register, the instruction buffer, a pending flag and a 40-bit accumulator.

The block drives a synchronous single-port memory through four signals: address, write data, write enable and read data. Read data arrives one clock after the address is presented. A write takes effect on the clock edge during which write enable is high. After reset the sequencer waits in idle. A one-cycle `start_i` pulse begins execution at the start address. The halt opcode stops the machine and keeps `halted_o` high until the next reset. The program counter and the accumulator are brought out so that their values can be observed.

Top module: `acc_pair_seq`

## Requirements
- R1: While reset is held and after it is released, before `start_i` is seen, `halted_o` is 0, `acc_o` is 0, `pc_o` equals START_ADDR and `mem_we_o` is 0.
- R2: Bit 39 of a word is its most significant bit. The left instruction is bits [39:20] and runs before the right instruction in bits [19:0]. Within each half, the upper 8 bits are the opcode and the lower 12 bits are the operand address.
- R3: Opcode 8'h01 (load) reads memory at the operand address and puts the value into the accumulator.
- R4: Opcode 8'h05 (add) reads memory at the operand address and adds the value to the accumulator, modulo 2^40.
- R5: Opcode 8'h21 (store) writes the accumulator to memory at the operand address in a single write cycle, with write data equal to the accumulator.
- R6: The right instruction runs from the buffer captured at the word fetch, even if the left instruction has since overwritten that memory word.
- R7: The program counter advances by one only after both halves of a word have run. Running word {load 500, add 501} at address 1, with M[500]=3 and M[501]=4, leaves the accumulator at 7 and the program counter at 2.
- R8: Opcode 8'h00 halts the machine. `halted_o` then stays 1, no more writes occur, the program counter stays put, and a halt in the left half means the right half never runs.
- R9: Any opcode other than 8'h00, 8'h01, 8'h05 and 8'h21 changes neither the accumulator nor memory.
- R10: For word {8'h33 no-op, halt} at START_ADDR, `halted_o` rises 7 clock cycles after the clock edge that samples `start_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start_i | input | 1 | One-cycle pulse that leaves idle and begins execution |
| mem_addr_o | output | ADDR_W | Memory address (memory address register) |
| mem_wdata_o | output | 40 | Memory write data (memory buffer register) |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 40 | Memory read data, valid one clock after the address |
| halted_o | output | 1 | High once the halt opcode has executed |
| pc_o | output | ADDR_W | Current program counter |
| acc_o | output | 40 | Current accumulator |

## Verification
The bench builds the block with START_ADDR set to 1 and ADDR_W left at 12. This lets the two-word program with operands at 500 and 501 run exactly at the addresses of the worked example, so the final program counter of 2 can be checked directly. Its memory model is 1024 words deep, which keeps every operand address in the tests in range. A program that stores into its own word shows that the right half runs from the buffer and not from a second fetch.

// File: rtl/pair_seq_pkg.sv
package pair_seq_pkg;
  localparam int WORD_W  = 40;
  localparam int HALF_W  = WORD_W / 2;
  localparam int OP_W    = 8;
  localparam int FIELD_W = HALF_W - OP_W;

  localparam logic [OP_W-1:0] OP_HALT = 8'h00;
  localparam logic [OP_W-1:0] OP_LOAD = 8'h01;
  localparam logic [OP_W-1:0] OP_ADD  = 8'h05;
  localparam logic [OP_W-1:0] OP_STOR = 8'h21;

  typedef enum logic [3:0] {
    S_IDLE, S_FADR, S_FRD, S_DECL, S_DECR,
    S_EXEC, S_RRD, S_ACC, S_WR, S_NEXT, S_HALT
  } seq_state_e;

  typedef struct packed {
    logic mar_pc;
    logic mbr_mem;
    logic dec_left;
    logic dec_right;
    logic mbr_ac;
    logic ac_load;
    logic ac_add;
    logic pc_inc;
    logic mem_we;
  } seq_ctl_t;
endpackage

// File: rtl/pair_seq_ctrl.sv
module pair_seq_ctrl
  import pair_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [OP_W-1:0]      op_i,
  input  logic                 pend_i,
  output seq_state_e           state_o,
  output seq_ctl_t             ctl_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    ctl_o   = '0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        ctl_o.mar_pc = 1'b1;
        state_d      = S_FADR;
      end
      S_FADR: state_d = S_FRD;
      S_FRD: begin
        ctl_o.mbr_mem = 1'b1;
        state_d       = S_DECL;
      end
      S_DECL: begin
        ctl_o.dec_left = 1'b1;
        state_d        = S_EXEC;
      end
      S_DECR: begin
        ctl_o.dec_right = 1'b1;
        state_d         = S_EXEC;
      end
      S_EXEC: begin
        case (op_i)
          OP_LOAD, OP_ADD: state_d = S_RRD;
          OP_STOR: begin
            ctl_o.mbr_ac = 1'b1;
            state_d      = S_WR;
          end
          OP_HALT: state_d = S_HALT;
          default: state_d = S_NEXT;
        endcase
      end
      S_RRD: begin
        ctl_o.mbr_mem = 1'b1;
        state_d       = S_ACC;
      end
      S_ACC: begin
        if (op_i == OP_LOAD) ctl_o.ac_load = 1'b1;
        else                 ctl_o.ac_add  = 1'b1;
        state_d = S_NEXT;
      end
      S_WR: begin
        ctl_o.mem_we = 1'b1;
        state_d      = S_NEXT;
      end
      S_NEXT: begin
        if (pend_i) state_d = S_DECR;
        else begin
          ctl_o.pc_inc = 1'b1;
          state_d      = S_FADR;
        end
      end
      S_HALT: state_d = S_HALT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

  p_halt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_HALT) |=> (state_q == S_HALT));
endmodule

// File: rtl/pair_seq_dp.sv
module pair_seq_dp
  import pair_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int START_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  seq_ctl_t             ctl_i,
  input  logic [WORD_W-1:0]    rdata_i,
  output logic [ADDR_W-1:0]    mar_o,
  output logic [WORD_W-1:0]    mbr_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [WORD_W-1:0]    acc_o,
  output logic [OP_W-1:0]      ir_o,
  output logic                 pend_o
);
  localparam logic [ADDR_W-1:0] PC_RST = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0] pc_q, pc_d, mar_q, mar_d;
  logic [WORD_W-1:0] mbr_q, mbr_d, acc_q, acc_d;
  logic [OP_W-1:0]   ir_q, ir_d;
  logic [HALF_W-1:0] ibr_q, ibr_d;
  logic              pend_q, pend_d;

  logic [HALF_W-1:0]  left_half;
  logic [FIELD_W-1:0] left_fld, right_fld;
  logic [ADDR_W-1:0]  pc_plus;

  assign left_half = mbr_q[WORD_W-1 -: HALF_W];
  assign left_fld  = left_half[FIELD_W-1:0];
  assign right_fld = ibr_q[FIELD_W-1:0];
  assign pc_plus   = pc_q + 1'b1;

  always_comb begin
    pc_d   = pc_q;
    mar_d  = mar_q;
    mbr_d  = mbr_q;
    acc_d  = acc_q;
    ir_d   = ir_q;
    ibr_d  = ibr_q;
    pend_d = pend_q;
    if (ctl_i.mar_pc)  mar_d = pc_q;
    if (ctl_i.mbr_mem) mbr_d = rdata_i;
    if (ctl_i.mbr_ac)  mbr_d = acc_q;
    if (ctl_i.dec_left) begin
      ir_d   = left_half[HALF_W-1 -: OP_W];
      mar_d  = left_fld[ADDR_W-1:0];
      ibr_d  = mbr_q[HALF_W-1:0];
      pend_d = 1'b1;
    end
    if (ctl_i.dec_right) begin
      ir_d   = ibr_q[HALF_W-1 -: OP_W];
      mar_d  = right_fld[ADDR_W-1:0];
      pend_d = 1'b0;
    end
    if (ctl_i.ac_load) acc_d = mbr_q;
    if (ctl_i.ac_add)  acc_d = acc_q + mbr_q;
    if (ctl_i.pc_inc) begin
      pc_d  = pc_plus;
      mar_d = pc_plus;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= PC_RST;
      mar_q  <= '0;
      mbr_q  <= '0;
      acc_q  <= '0;
      ir_q   <= '0;
      ibr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      mar_q  <= mar_d;
      mbr_q  <= mbr_d;
      acc_q  <= acc_d;
      ir_q   <= ir_d;
      ibr_q  <= ibr_d;
      pend_q <= pend_d;
    end
  end

  assign mar_o  = mar_q;
  assign mbr_o  = mbr_q;
  assign pc_o   = pc_q;
  assign acc_o  = acc_q;
  assign ir_o   = ir_q;
  assign pend_o = pend_q;

  // PC moves only when no right half is waiting
  p_pc_after_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc_q) |-> !$past(pend_q));
  // buffered right half is not disturbed while pending
  p_ibr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && $past(pend_q)) |-> $stable(ibr_q));
endmodule

// File: rtl/acc_pair_seq.sv
module acc_pair_seq
  import pair_seq_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int START_ADDR = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  output logic [ADDR_W-1:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  output logic                 mem_we_o,
  input  logic [WORD_W-1:0]    mem_rdata_i,
  output logic                 halted_o,
  output logic [ADDR_W-1:0]    pc_o,
  output logic [WORD_W-1:0]    acc_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  seq_state_e       state;
  seq_ctl_t         ctl;
  logic [OP_W-1:0]  ir;
  logic             pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  pair_seq_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start_i (start_i),
    .op_i    (ir),
    .pend_i  (pend),
    .state_o (state),
    .ctl_o   (ctl)
  );

  pair_seq_dp #(
    .ADDR_W     (ADDR_W),
    .START_ADDR (START_ADDR)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .ctl_i   (ctl),
    .rdata_i (mem_rdata_i),
    .mar_o   (mem_addr_o),
    .mbr_o   (mem_wdata_o),
    .pc_o    (pc_o),
    .acc_o   (acc_o),
    .ir_o    (ir),
    .pend_o  (pend)
  );

  assign mem_we_o = ctl.mem_we;
  assign halted_o = (state == S_HALT);

  p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_int_n)
    mem_we_o |-> (mem_wdata_o == acc_o));
  p_halt_quiet_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    halted_o |=> ($stable(pc_o) && !mem_we_o));
  p_nop_keeps_ac_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((state == S_EXEC) && (ir != OP_LOAD) && (ir != OP_ADD)) |=> $stable(acc_o));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_int_n)
    (state == S_IDLE) |-> (!mem_we_o && acc_o == '0));
endmodule

// File: tb/tb_acc_pair_seq.sv
`timescale 1ns/1ps
module tb_acc_pair_seq;
  localparam int AW = 12;
  localparam int MD = 1024;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [39:0]   mem_wdata;
  logic          mem_we;
  logic [39:0]   mem_rdata;
  logic          halted;
  logic [AW-1:0] pc;
  logic [39:0]   acc;

  logic [39:0]   mem [MD];
  logic          pl_en = 1'b0;
  logic [9:0]    pl_addr = '0;
  logic [39:0]   pl_data = '0;

  int tests = 0;
  int fails = 0;
  int wr_cnt = 0;
  int cyc = 0;
  int last_cycles = 0;

  always #4 clk = ~clk;

  acc_pair_seq #(.ADDR_W(AW), .START_ADDR(1)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .mem_rdata_i(mem_rdata), .halted_o(halted), .pc_o(pc), .acc_o(acc)
  );

  always @(posedge clk) begin
    if (pl_en) mem[pl_addr] <= pl_data;
    else if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[9:0]];
    if (mem_we) wr_cnt <= wr_cnt + 1;
    cyc <= cyc + 1;
  end

  function automatic logic [39:0] mkw(input logic [7:0] ol, input logic [11:0] al,
                                      input logic [7:0] orr, input logic [11:0] ar);
    return {ol, al, orr, ar};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
  endtask

  task automatic poke(input int a, input logic [39:0] d);
    @(negedge clk);
    pl_en = 1'b1; pl_addr = 10'(a); pl_data = d;
    @(negedge clk);
    pl_en = 1'b0;
  endtask

  task automatic release_reset();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic go();
    wr_cnt = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    last_cycles = 0;
    while (!halted && last_cycles < 500) begin
      @(negedge clk);
      last_cycles++;
    end
    if (!halted) chk(1'b0, "halt reached", 0, 1);
  endtask

  task automatic t_reset();
    hold_reset();
    @(negedge clk);
    chk(halted == 1'b0 && acc == '0 && pc == 12'd1, "R1 in reset", {halted, pc, acc}, {1'b0, 12'd1, 40'd0});
    release_reset();
    for (int i = 0; i < 5; i++) begin
      chk(!mem_we && !halted, "R1 idle quiet", {mem_we, halted}, 0);
      @(negedge clk);
    end
    chk(acc == '0 && pc == 12'd1, "R1 idle state", {pc, acc}, {12'd1, 40'd0});
  endtask

  task automatic t_example();
    hold_reset();
    poke(1, mkw(8'h01, 12'd500, 8'h05, 12'd501));
    poke(2, mkw(8'h21, 12'd502, 8'h00, 12'd0));
    poke(500, 40'd3); poke(501, 40'd4); poke(502, 40'd0);
    release_reset();
    go();
    chk(acc == 40'd7, "R7 R2 R3 R4 accumulator", acc, 7);
    chk(pc == 12'd2, "R7 program counter", pc, 2);
    chk(mem[502] == 40'd7, "R5 stored value", mem[502], 7);
    chk(wr_cnt == 1, "R5 single write", wr_cnt, 1);
  endtask

  task automatic t_buffer();
    hold_reset();
    poke(1, mkw(8'h21, 12'd1, 8'h01, 12'd600));
    poke(2, mkw(8'h21, 12'd601, 8'h00, 12'd0));
    poke(600, 40'h55); poke(601, 40'd0);
    release_reset();
    go();
    chk(mem[1] == 40'd0, "R6 word overwritten", mem[1], 0);
    chk(mem[601] == 40'h55, "R6 right half from buffer", mem[601], 40'h55);
    chk(pc == 12'd2, "R6 program counter", pc, 2);
  endtask

  task automatic t_wrap();
    hold_reset();
    poke(1, mkw(8'h01, 12'd600, 8'h05, 12'd601));
    poke(2, mkw(8'h21, 12'd602, 8'h00, 12'd0));
    poke(600, 40'hFF_FFFF_FFFF); poke(601, 40'd2); poke(602, 40'd0);
    release_reset();
    go();
    chk(acc == 40'd1, "R4 wrap", acc, 1);
    chk(mem[602] == 40'd1, "R4 wrap stored", mem[602], 1);
  endtask

  task automatic t_nop();
    hold_reset();
    poke(1, mkw(8'h01, 12'd600, 8'h33, 12'd600));
    poke(2, mkw(8'h21, 12'd601, 8'h00, 12'd0));
    poke(600, 40'd9); poke(601, 40'd0);
    release_reset();
    go();
    chk(acc == 40'd9, "R9 accumulator unchanged", acc, 9);
    chk(mem[601] == 40'd9 && mem[600] == 40'd9, "R9 memory", mem[601], 9);
    chk(wr_cnt == 1, "R9 no extra write", wr_cnt, 1);
  endtask

  task automatic t_halt_left();
    hold_reset();
    poke(1, mkw(8'h00, 12'd0, 8'h21, 12'd600));
    poke(600, 40'hAB);
    release_reset();
    go();
    repeat (20) @(negedge clk);
    chk(halted == 1'b1, "R8 halt sticky", halted, 1);
    chk(pc == 12'd1, "R8 pc held", pc, 1);
    chk(mem[600] == 40'hAB && wr_cnt == 0, "R8 right half skipped", mem[600], 40'hAB);
  endtask

  task automatic t_timing();
    hold_reset();
    poke(1, mkw(8'h33, 12'd0, 8'h00, 12'd0));
    release_reset();
    go();
    chk(last_cycles == 7, "R10 start-to-halt cycles", last_cycles, 7);
    chk(acc == '0, "R9 no-op leaves zero", acc, 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_example();
        t_buffer();
        t_wrap();
        t_nop();
        t_halt_left();
        t_timing();
      end
      begin
        wait (cyc >= 200000);
        chk(1'b0, "watchdog", cyc, 0);
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule